// File: doc/BRIEF.md
# Microcontroller Internal Data Space Controller

This block serves the 256-byte on-chip data space of an 8-bit microcontroller core. The core's decoder presents one request per clock: an operation code, an 8-bit address, write data and the current status word. The block steers each request to one of three places, based on the address and on how the address was formed. The lower 128 bytes are one storage array that every mode can reach. A separate 128-byte upper array serves register-indirect accesses above 0x7F. The special-function-register bus serves direct accesses above 0x7F.

On top of plain byte access, the block remaps working-register numbers and bit numbers onto the lower array. Register numbers map into one of four eight-byte banks, chosen by the status word. Bit numbers map into a sixteen-byte bit field, and a bit set or clear is a single-cycle read-modify-write. The block also forms the address for external data cycles. That address is either an 8-bit pointer held in working register 0 or 1 of the active bank, or the 16-bit data pointer passed straight through.

Read results appear one clock after the request and report the value held before any write made in that request's cycle.

Top module: `dmem_space_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid`, `xaddr_valid`, `sfr_rd` and `sfr_wr` are 0 and every storage byte reads back 0.
- R2: Operation codes are NOP=0, direct read=1, direct write=2, indirect read=3, indirect write=4, register read=5, register write=6, bit read=7, bit set=8, bit clear=9, pointer from R0/R1=10, pointer from data pointer=11. Direct and indirect accesses to 0x00–0x7F reach the same lower bytes. A read raises `rd_valid` for exactly the next cycle, and `rd_data` then carries the byte.
- R3: A direct access to 0x80–0xFF raises `sfr_rd` or `sfr_wr` in the request cycle, with `sfr_addr` set to the address. It changes no internal byte. The `rd_data` of a direct read is the `sfr_rdata` value presented in the following cycle.
- R4: An indirect access to 0x80–0xFF reads or writes the separate upper array and never raises `sfr_rd` or `sfr_wr`.
- R5: A register access with register number n (address bits 2:0) reaches lower byte {status[4:3], n}.
- R6: A bit access with bit number b below 0x80 reaches lower byte 0x20 + b[6:3], bit b[2:0]. A set or clear changes that bit alone. `rd_bit` returns the bit and `rd_data` returns the whole byte.
- R7: Bit set and bit clear also report the byte and the bit as they were before the modification.
- R8: A bit operation whose bit number has bit 7 set is ignored. It changes no byte, raises no strobe and gives no `rd_valid`.
- R9: Operation 10 yields `xaddr` = {0x00, byte at {status[4:3], 2'b00, address bit 0}}. Operation 11 yields `xaddr` = `dptr`. Each one raises `xaddr_valid` for the next cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 4 | Operation code (see R2) |
| req_addr | input | 8 | Byte, register or bit address |
| req_wdata | input | 8 | Write data |
| psw | input | 8 | Status word; bits 4:3 select the register bank |
| dptr | input | 16 | Data pointer for external data cycles |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| rd_bit | output | 1 | Read result bit for bit operations |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rd | output | 1 | SFR bus read strobe |
| sfr_wr | output | 1 | SFR bus write strobe |
| sfr_rdata | input | 8 | SFR bus read data, presented the cycle after `sfr_rd` |
| xaddr | output | 16 | External data address |
| xaddr_valid | output | 1 | External data address valid |

## Verification
The assertions assume that the request inputs carry exactly one defined operation code (0 to 11) in every cycle after reset, and that `req_op` stays at NOP while reset is held. They also assume that the SFR bus returns `sfr_rdata` one cycle after `sfr_rd`. The stimulus drives only the twelve defined codes, holds NOP during reset, and models the SFR bus as a register that captures a fixed function of the strobed address. Random phases pick codes, addresses, bank bits and pointer values freely within that set. Directed phases cover every bank, both halves of the address space and out-of-range bit numbers.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_DRD  = 4'd1,
      OP_DWR  = 4'd2,
      OP_IRD  = 4'd3,
      OP_IWR  = 4'd4,
      OP_RRD  = 4'd5,
      OP_RWR  = 4'd6,
      OP_BRD  = 4'd7,
      OP_BSET = 4'd8,
      OP_BCLR = 4'd9,
      OP_XRI  = 4'd10,
      OP_XDP  = 4'd11
   } dm_op_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_LOW  = 2'd1,
      TGT_UP   = 2'd2,
      TGT_SFR  = 2'd3
   } dm_tgt_e;

   localparam int unsigned DM_IDX_W = 7;

   typedef struct packed {
      dm_tgt_e             tgt;
      logic [DM_IDX_W-1:0] idx;
      logic                rd;
      logic                wr;
      logic                rmw;
      logic                set;
      logic                bitop;
      logic [2:0]          bpos;
      logic                xri;
      logic                xdp;
   } dm_dec_t;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
   import dmem_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BANK_LSB = 3,
   parameter int unsigned BIT_BASE = 32
) (
   input  logic [3:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        psw,
   output dm_dec_t           dec
);

   localparam int unsigned IDX_W = ADDR_W - 1;

   logic [1:0]       bank;
   logic             hi;
   logic [IDX_W-1:0] reg_idx;
   logic [IDX_W-1:0] ptr_idx;
   logic [IDX_W-1:0] bit_idx;
   logic             unused_psw;

   assign bank       = psw[BANK_LSB +: 2];
   assign unused_psw = ^psw;
   assign hi         = addr[ADDR_W-1];
   assign reg_idx    = IDX_W'({bank, addr[2:0]});
   assign ptr_idx    = IDX_W'({bank, 2'b00, addr[0]});
   assign bit_idx    = IDX_W'(BIT_BASE) + IDX_W'(addr[IDX_W-1:3]);

   always_comb begin
      dec      = '0;
      dec.tgt  = TGT_NONE;
      dec.bpos = addr[2:0];
      unique case (dm_op_e'(op))
         OP_DRD, OP_DWR: begin
            dec.tgt = hi ? TGT_SFR : TGT_LOW;
            dec.idx = addr[IDX_W-1:0];
            dec.rd  = (dm_op_e'(op) == OP_DRD);
            dec.wr  = (dm_op_e'(op) == OP_DWR);
         end
         OP_IRD, OP_IWR: begin
            dec.tgt = hi ? TGT_UP : TGT_LOW;
            dec.idx = addr[IDX_W-1:0];
            dec.rd  = (dm_op_e'(op) == OP_IRD);
            dec.wr  = (dm_op_e'(op) == OP_IWR);
         end
         OP_RRD, OP_RWR: begin
            dec.tgt = TGT_LOW;
            dec.idx = reg_idx;
            dec.rd  = (dm_op_e'(op) == OP_RRD);
            dec.wr  = (dm_op_e'(op) == OP_RWR);
         end
         OP_BRD, OP_BSET, OP_BCLR: begin
            if (!hi) begin
               dec.tgt   = TGT_LOW;
               dec.idx   = bit_idx;
               dec.rd    = 1'b1;
               dec.bitop = 1'b1;
               dec.rmw   = (dm_op_e'(op) != OP_BRD);
               dec.set   = (dm_op_e'(op) == OP_BSET);
            end
         end
         OP_XRI: begin
            dec.tgt = TGT_LOW;
            dec.idx = ptr_idx;
            dec.xri = 1'b1;
         end
         OP_XDP: begin
            dec.xdp = 1'b1;
         end
         default: begin
            dec.tgt = TGT_NONE;
         end
      endcase
   end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] rows [DEPTH];

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (idx == IDX_W'(r))) begin
            q <= wdata;
         end
      end
      assign rows[r] = q;
   end

   assign rdata = rows[idx];

endmodule

// File: rtl/dmem_space_ctrl.sv
module dmem_space_ctrl
   import dmem_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned XADDR_W  = 16,
   parameter int unsigned BANK_LSB = 3,
   parameter int unsigned BIT_BASE = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [7:0]         psw,
   input  logic [XADDR_W-1:0] dptr,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_bit,
   output logic [ADDR_W-1:0]  sfr_addr,
   output logic [DATA_W-1:0]  sfr_wdata,
   output logic               sfr_rd,
   output logic               sfr_wr,
   input  logic [DATA_W-1:0]  sfr_rdata,
   output logic [XADDR_W-1:0] xaddr,
   output logic               xaddr_valid
);

   localparam int unsigned HALF  = 1 << (ADDR_W - 1);
   localparam int unsigned IDX_W = ADDR_W - 1;
   localparam int unsigned XPAD  = XADDR_W - DATA_W;

   if (ADDR_W != 8) begin : g_bad_addr_w
      $error("dmem_space_ctrl: ADDR_W must be 8");
   end
   if (DATA_W != 8) begin : g_bad_data_w
      $error("dmem_space_ctrl: DATA_W must be 8 for bit mapping");
   end
   if (XADDR_W <= DATA_W) begin : g_bad_xaddr_w
      $error("dmem_space_ctrl: XADDR_W must exceed DATA_W");
   end
   if (BANK_LSB > 6) begin : g_bad_bank_lsb
      $error("dmem_space_ctrl: bank field must fit the status word");
   end
   if (BIT_BASE + (HALF / DATA_W) > HALF) begin : g_bad_bit_base
      $error("dmem_space_ctrl: bit field must fit the lower half");
   end

   dm_dec_t dec;

   dmem_decode #(
      .ADDR_W   (ADDR_W),
      .BANK_LSB (BANK_LSB),
      .BIT_BASE (BIT_BASE)
   ) u_decode (
      .op   (req_op),
      .addr (req_addr),
      .psw  (psw),
      .dec  (dec)
   );

   logic              lo_we;
   logic [DATA_W-1:0] lo_wdata;
   logic [DATA_W-1:0] lo_rd;
   logic              up_we;
   logic [DATA_W-1:0] up_rd;
   logic [DATA_W-1:0] bmask;

   assign bmask    = DATA_W'(1) << dec.bpos;
   assign lo_we    = (dec.tgt == TGT_LOW) && (dec.wr || dec.rmw);
   assign lo_wdata = !dec.rmw ? req_wdata :
                     dec.set  ? (lo_rd | bmask) : (lo_rd & ~bmask);
   assign up_we    = (dec.tgt == TGT_UP) && dec.wr;

   dmem_bank #(
      .DEPTH (HALF),
      .WIDTH (DATA_W)
   ) u_lower (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lo_we),
      .idx   (dec.idx),
      .wdata (lo_wdata),
      .rdata (lo_rd)
   );

   dmem_bank #(
      .DEPTH (HALF),
      .WIDTH (DATA_W)
   ) u_upper (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (up_we),
      .idx   (dec.idx),
      .wdata (req_wdata),
      .rdata (up_rd)
   );

   assign sfr_addr  = req_addr;
   assign sfr_wdata = req_wdata;
   assign sfr_rd    = (dec.tgt == TGT_SFR) && dec.rd;
   assign sfr_wr    = (dec.tgt == TGT_SFR) && dec.wr;

   logic              rsp_valid;
   logic              rsp_sfr;
   logic [DATA_W-1:0] rsp_byte;
   logic              rsp_bit;
   logic              x_valid;
   logic [XADDR_W-1:0] x_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_sfr   <= 1'b0;
         rsp_byte  <= '0;
         rsp_bit   <= 1'b0;
         x_valid   <= 1'b0;
         x_q       <= '0;
      end else begin
         rsp_valid <= dec.rd;
         rsp_sfr   <= (dec.tgt == TGT_SFR);
         rsp_byte  <= (dec.tgt == TGT_UP) ? up_rd : lo_rd;
         rsp_bit   <= lo_rd[dec.bpos];
         x_valid   <= dec.xri || dec.xdp;
         if (dec.xri) begin
            x_q <= {{XPAD{1'b0}}, lo_rd};
         end else if (dec.xdp) begin
            x_q <= dptr;
         end
      end
   end

   assign rd_valid    = rsp_valid;
   assign rd_data     = rsp_sfr ? sfr_rdata : rsp_byte;
   assign rd_bit      = rsp_bit;
   assign xaddr       = x_q;
   assign xaddr_valid = x_valid;

   // R1: strobes quiet in the first cycle out of reset
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !rd_valid && !xaddr_valid);

   // R2: result valid exactly one cycle after a read request
   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rd_valid == $past(
         (req_op == OP_DRD) || (req_op == OP_IRD) || (req_op == OP_RRD) ||
         (((req_op == OP_BRD) || (req_op == OP_BSET) || (req_op == OP_BCLR)) &&
          !req_addr[ADDR_W-1])));

   // R3: an SFR bus cycle never writes internal storage
   assert_sfr_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rd || sfr_wr) |-> !lo_we && !up_we && !(sfr_rd && sfr_wr));

   // R4: indirect accesses keep the SFR bus idle
   assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_op == OP_IRD) || (req_op == OP_IWR)) |-> !sfr_rd && !sfr_wr);

   // R5: register accesses stay in the active bank
   assert_bank_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_op == OP_RRD) || (req_op == OP_RWR)) |->
         (dec.idx[IDX_W-1:5] == '0) && (dec.idx[4:3] == psw[BANK_LSB +: 2]));

   // R6: bit modification flips at most the addressed bit
   assert_bit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && dec.rmw) |-> ($countones(lo_wdata ^ lo_rd) <= 1) &&
         ((lo_wdata ^ lo_rd) & ~bmask) == '0);

   // R8: out-of-range bit numbers touch nothing
   assert_bit_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((req_op == OP_BRD) || (req_op == OP_BSET) || (req_op == OP_BCLR)) &&
       req_addr[ADDR_W-1]) |-> !lo_we && !up_we && !sfr_rd && !sfr_wr);

   // R9: pointer output valid one cycle after a pointer request
   assert_xaddr_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> xaddr_valid == $past((req_op == OP_XRI) || (req_op == OP_XDP)));

endmodule

// File: tb/dmem_space_ctrl_tb.sv
`timescale 1ns/1ps
module dmem_space_ctrl_tb_top;
   import dmem_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req_op = 4'd0;
   logic [7:0]  req_addr = 8'd0;
   logic [7:0]  req_wdata = 8'd0;
   logic [7:0]  psw = 8'd0;
   logic [15:0] dptr = 16'd0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        rd_bit;
   logic [7:0]  sfr_addr;
   logic [7:0]  sfr_wdata;
   logic        sfr_rd;
   logic        sfr_wr;
   logic [7:0]  sfr_rdata;
   logic [15:0] xaddr;
   logic        xaddr_valid;

   always #4 clk = ~clk;

   dmem_space_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_op      (req_op),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .psw         (psw),
      .dptr        (dptr),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .rd_bit      (rd_bit),
      .sfr_addr    (sfr_addr),
      .sfr_wdata   (sfr_wdata),
      .sfr_rd      (sfr_rd),
      .sfr_wr      (sfr_wr),
      .sfr_rdata   (sfr_rdata),
      .xaddr       (xaddr),
      .xaddr_valid (xaddr_valid)
   );

   // SFR bus model: returns a fixed function of the strobed address next cycle
   logic [7:0] sfr_q = 8'd0;
   always_ff @(posedge clk) if (sfr_rd) sfr_q <= sfr_addr ^ 8'hC3;
   assign sfr_rdata = sfr_q;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] lo [128];
   logic [7:0] up [128];

   bit          e_rv = 0;
   logic [7:0]  e_rd = 0;
   bit          e_bitop = 0;
   bit          e_bit = 0;
   bit          e_xv = 0;
   logic [15:0] e_xa = 0;
   string       e_tag = "R1";

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(logic [3:0] op, logic [7:0] a, logic [7:0] wd,
                       logic [7:0] ps, logic [15:0] dp);
      logic [1:0] bank;
      int         i;
      bit         x_rd, x_wr;
      @(negedge clk);
      // response to the previous request
      chk(rd_valid == e_rv, e_tag, "rd_valid", 32'(rd_valid), 32'(e_rv));
      if (e_rv) chk(rd_data == e_rd, e_tag, "rd_data", 32'(rd_data), 32'(e_rd));
      if (e_rv && e_bitop) chk(rd_bit == e_bit, e_tag, "rd_bit", 32'(rd_bit), 32'(e_bit));
      chk(xaddr_valid == e_xv, "R9", "xaddr_valid", 32'(xaddr_valid), 32'(e_xv));
      if (e_xv) chk(xaddr == e_xa, "R9", "xaddr", 32'(xaddr), 32'(e_xa));
      req_op = op; req_addr = a; req_wdata = wd; psw = ps; dptr = dp;
      #1;
      x_rd = (op == OP_DRD) && a[7];
      x_wr = (op == OP_DWR) && a[7];
      chk(sfr_rd == x_rd, (op == OP_IRD || op == OP_IWR) ? "R4" : "R3", "sfr_rd",
          32'(sfr_rd), 32'(x_rd));
      chk(sfr_wr == x_wr, (op == OP_IRD || op == OP_IWR) ? "R4" : "R3", "sfr_wr",
          32'(sfr_wr), 32'(x_wr));
      if (x_rd || x_wr) begin
         chk(sfr_addr == a, "R3", "sfr_addr", 32'(sfr_addr), 32'(a));
         if (x_wr) chk(sfr_wdata == wd, "R3", "sfr_wdata", 32'(sfr_wdata), 32'(wd));
      end
      // reference model update
      bank = ps[4:3];
      e_rv = 0; e_bitop = 0; e_xv = 0; e_tag = "R2";
      case (op)
         OP_DRD: begin
            e_rv = 1;
            if (a[7]) begin e_rd = a ^ 8'hC3; e_tag = "R3"; end
            else e_rd = lo[a[6:0]];
         end
         OP_DWR: if (!a[7]) lo[a[6:0]] = wd;
         OP_IRD: begin
            e_rv = 1;
            if (a[7]) begin e_rd = up[a[6:0]]; e_tag = "R4"; end
            else e_rd = lo[a[6:0]];
         end
         OP_IWR: if (a[7]) up[a[6:0]] = wd; else lo[a[6:0]] = wd;
         OP_RRD: begin
            e_rv = 1; e_tag = "R5";
            e_rd = lo[{bank, a[2:0]}];
         end
         OP_RWR: lo[{bank, a[2:0]}] = wd;
         OP_BRD, OP_BSET, OP_BCLR: begin
            if (a[7]) begin
               e_tag = "R8";
            end else begin
               i = 32 + int'(a[6:3]);
               e_rv = 1; e_bitop = 1;
               e_tag = (op == OP_BRD) ? "R6" : "R7";
               e_rd = lo[i];
               e_bit = lo[i][a[2:0]];
               if (op == OP_BSET) lo[i][a[2:0]] = 1'b1;
               if (op == OP_BCLR) lo[i][a[2:0]] = 1'b0;
            end
         end
         OP_XRI: begin
            e_xv = 1;
            e_xa = {8'h00, lo[{bank, 2'b00, a[0]}]};
         end
         OP_XDP: begin
            e_xv = 1;
            e_xa = dp;
         end
         default: ;
      endcase
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      for (int k = 0; k < 128; k++) begin lo[k] = 8'h00; up[k] = 8'h00; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet during reset
      chk(rd_valid == 0, "R1", "rd_valid in reset", 32'(rd_valid), 0);
      chk(xaddr_valid == 0, "R1", "xaddr_valid in reset", 32'(xaddr_valid), 0);
      chk(!sfr_rd && !sfr_wr, "R1", "strobes in reset", 32'({sfr_rd, sfr_wr}), 0);
      rst_n = 1'b1;
      // R1: storage clear after reset
      step(OP_DRD, 8'h05, 0, 0, 0);
      step(OP_IRD, 8'hA0, 0, 0, 0);
      // R2: direct and indirect share the lower half
      step(OP_DWR, 8'h40, 8'h3C, 0, 0);
      step(OP_IRD, 8'h40, 0, 0, 0);
      step(OP_IWR, 8'h7F, 8'hE1, 0, 0);
      step(OP_DRD, 8'h7F, 0, 0, 0);
      step(OP_DRD, 8'h00, 0, 0, 0);
      // R4 and R3: upper half split by mode
      step(OP_IWR, 8'h90, 8'h77, 0, 0);
      step(OP_DRD, 8'h90, 0, 0, 0);
      step(OP_IRD, 8'h90, 0, 0, 0);
      step(OP_DWR, 8'h90, 8'h11, 0, 0);
      step(OP_IRD, 8'h90, 0, 0, 0);
      step(OP_DWR, 8'hFF, 8'h22, 0, 0);
      step(OP_DRD, 8'h7F, 0, 0, 0);
      step(OP_IRD, 8'hFF, 0, 0, 0);
      // R5: each bank with its own registers
      for (int b = 0; b < 4; b++)
         for (int n = 0; n < 8; n++)
            step(OP_RWR, 8'(n), 8'(b * 16 + n + 1), 8'(b << 3), 0);
      for (int b = 0; b < 4; b++) begin
         step(OP_RRD, 8'h03, 0, 8'(b << 3) | 8'hE7, 0);
         step(OP_DRD, 8'(b * 8 + 3), 0, 0, 0);
      end
      // R6 and R7: bit map and read-modify-write
      step(OP_DWR, 8'h20, 8'hA5, 0, 0);
      step(OP_BRD, 8'h00, 0, 0, 0);
      step(OP_BRD, 8'h01, 0, 0, 0);
      step(OP_BSET, 8'h01, 0, 0, 0);
      step(OP_BSET, 8'h01, 0, 0, 0);
      step(OP_BCLR, 8'h07, 0, 0, 0);
      step(OP_DRD, 8'h20, 0, 0, 0);
      step(OP_BSET, 8'h7F, 0, 0, 0);
      step(OP_DRD, 8'h2F, 0, 0, 0);
      step(OP_BCLR, 8'h7F, 0, 0, 0);
      // R8: bit numbers with bit 7 set are ignored
      step(OP_BSET, 8'h80, 0, 0, 0);
      step(OP_BCLR, 8'hA1, 0, 0, 0);
      step(OP_BRD, 8'hFF, 0, 0, 0);
      step(OP_DRD, 8'h20, 0, 0, 0);
      step(OP_IRD, 8'h90, 0, 0, 0);
      // R9: external address formation
      step(OP_XRI, 8'h00, 0, 8'h10, 0);
      step(OP_XRI, 8'h01, 0, 8'h18, 0);
      step(OP_XDP, 8'h00, 0, 0, 16'hBEEF);
      step(OP_NOP, 8'h00, 0, 0, 16'h1234);
      // random mix against the reference model
      for (int k = 0; k < 3000; k++)
         step(4'($urandom_range(11)), 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
      step(OP_NOP, 0, 0, 0, 0);
      step(OP_NOP, 0, 0, 0, 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule